// File: doc/BRIEF.md
# Common-Mode Voltage Step Monitor

This block observes the switch states of the three legs of a two-level inverter and classifies each newly applied switching state by the common-mode voltage it places on the load star point. Each leg bit is 1 when the upper switch conducts and 0 when the lower switch conducts. The common-mode level is set by how many legs are high. It is reported as a signed integer in units of one sixth of the DC-link voltage.

Each time a strobe marks a new state, the block also measures how far the common-mode level moved from the last accepted state. That step size is reported in units of one third of the DC-link voltage. The block raises a flag whenever the accepted state is one of the two null states, where all legs are low or all legs are high. A saturating counter records how many steps of two thirds of the DC-link voltage or more have occurred since reset. A modulator under test, or a protection path, can use these outputs to confirm that a reduced common-mode pattern never touches the null states and never produces large common-mode jumps.

Top module: `cmv_step_monitor`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the outputs show the baseline state with all legs low: level -3, step 0, null flag 1 and count 0.
- R2: A state accepted with the strobe high appears on the level output in the cycle after the strobe edge. The level equals 2k-3, where k is the number of high legs: -3, -1, +1 or +3, as a 3-bit two's complement value.
- R3: A move between two states of the same class gives step 0. The classes are: both states with exactly one leg high, or both states with exactly two legs high, or the same null state repeated.
- R4: A move between a one-high state and a two-high state, between a one-high state and 000, or between a two-high state and 111, gives step 1.
- R5: A move between a one-high state and 111, or between a two-high state and 000, gives step 2.
- R6: A move between 000 and 111, in either direction, gives step 3.
- R7: The null flag is 1 exactly when the last accepted state is 000 or 111.
- R8: When the strobe is low, the leg inputs are ignored and all outputs hold. The next accepted state is then measured against the last accepted state.
- R9: The big-step count rises by one for each accepted step of 2 or 3. It stops at its maximum, 2^CNT_W-1, and does not wrap.
- R10: Accepted steps of 0 or 1 leave the big-step count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| leg_a | input | 1 | First leg switch state, 1 = upper switch on |
| leg_b | input | 1 | Second leg switch state |
| leg_c | input | 1 | Third leg switch state |
| state_vld | input | 1 | Marks the leg bits as a new switching state |
| cm_level | output | 3 | Common-mode level, signed, units of Vdc/6 |
| cm_step | output | 2 | Size of the last step, units of Vdc/3 |
| null_vec | output | 1 | Last accepted state is 000 or 111 |
| big_step_cnt | output | CNT_W | Saturating count of steps of 2Vdc/3 or more |

## Verification
Two events can fall in the same cycle. One is a large step that should advance the counter. The other is a counter already at its maximum. A run of alternating 000 and 111 states, each producing a step of 3 with the null flag set, drives the count to saturation and keeps pushing after that. In those cycles the step output must still read 3 while the count stays pinned. The same transition also makes the null flag and the worst-case step occur together. The bench therefore judges the level, step, flag and count in every cycle against its own model.

// File: rtl/cmv_pkg.sv
package cmv_pkg;

    localparam int NLEGS  = 3;
    localparam int LVL_W  = $clog2(2 * NLEGS + 1);
    localparam int STEP_W = $clog2(NLEGS + 1);

    typedef logic [NLEGS-1:0]         legs_t;
    typedef logic signed [LVL_W-1:0]  level_t;
    typedef logic [STEP_W-1:0]        step_t;

    typedef struct packed {
        level_t level;
        step_t  step;
        logic   is_null;
    } mon_state_t;

    localparam level_t LEVEL_BASE = level_t'(-NLEGS);

endpackage

// File: rtl/cmv_level_decode.sv
module cmv_level_decode
    import cmv_pkg::*;
(
    input  legs_t  legs,
    output level_t level,
    output logic   is_null
);

    step_t ones;
    int    lv;

    always_comb begin
        ones = '0;
        for (int i = 0; i < NLEGS; i++) begin
            ones = ones + step_t'(legs[i]);
        end
        lv      = 2 * int'(ones) - NLEGS;
        level   = level_t'(lv);
        is_null = (legs == '0) || (legs == '1);
    end

endmodule

// File: rtl/cmv_step_class.sv
module cmv_step_class
    import cmv_pkg::*;
#(
    parameter int BIG_MIN = 2
) (
    input  level_t prev_level,
    input  level_t new_level,
    output step_t  step,
    output logic   big
);

    logic signed [LVL_W:0] diff;
    logic [LVL_W:0]        mag;

    always_comb begin
        diff = (LVL_W+1)'(new_level) - (LVL_W+1)'(prev_level);
        mag  = diff[LVL_W] ? (LVL_W+1)'(-diff) : (LVL_W+1)'(diff);
        step = step_t'(mag >> 1);
        big  = (int'(step) >= BIG_MIN);
    end

endmodule

// File: rtl/cmv_sat_counter.sv
module cmv_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R9

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/cmv_step_monitor.sv
module cmv_step_monitor
    import cmv_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int BIG_MIN = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    leg_a,
    input  logic                    leg_b,
    input  logic                    leg_c,
    input  logic                    state_vld,
    output logic signed [LVL_W-1:0] cm_level,
    output logic [STEP_W-1:0]       cm_step,
    output logic                    null_vec,
    output logic [CNT_W-1:0]        big_step_cnt
);

    legs_t      legs;
    level_t     new_level;
    logic       new_null;
    step_t      new_step;
    logic       new_big;
    mon_state_t state_d, state_q;

    assign legs = {leg_a, leg_b, leg_c};

    cmv_level_decode u_decode (
        .legs    (legs),
        .level   (new_level),
        .is_null (new_null)
    );

    cmv_step_class #(.BIG_MIN(BIG_MIN)) u_class (
        .prev_level (state_q.level),
        .new_level  (new_level),
        .step       (new_step),
        .big        (new_big)
    );

    cmv_sat_counter #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (state_vld && new_big),
        .count (big_step_cnt)
    );

    always_comb begin
        state_d = state_q;
        if (state_vld) begin
            state_d.level   = new_level;
            state_d.step    = new_step;
            state_d.is_null = new_null;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.level   <= LEVEL_BASE;
            state_q.step    <= '0;
            state_q.is_null <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign cm_level = state_q.level;
    assign cm_step  = state_q.step;
    assign null_vec = state_q.is_null;

    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cm_level) == -3 || int'(cm_level) == -1 ||
         int'(cm_level) == 1 || int'(cm_level) == 3)); // R2

    AST_NULL_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
        null_vec |-> (int'(cm_level) == 3 || int'(cm_level) == -3)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !state_vld |=> ($stable(cm_level) && $stable(cm_step) && $stable(null_vec))); // R8

    AST_STEP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        state_vld |=> (2 * int'(cm_step) ==
            ((int'(cm_level) >= int'($past(cm_level)))
                ? int'(cm_level) - int'($past(cm_level))
                : int'($past(cm_level)) - int'(cm_level)))); // R3

endmodule

// File: tb/cmv_step_monitor_tb.sv
module cmv_step_monitor_tb;

    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2:0]        legs;
    logic              vld;
    logic signed [2:0] lvl;
    logic [1:0]        stp;
    logic              nul;
    logic [CNT_W-1:0]  cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int m_level, m_step, m_null, m_cnt;

    always #4 clk = ~clk;

    cmv_step_monitor #(.CNT_W(CNT_W), .BIG_MIN(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .leg_a        (legs[2]),
        .leg_b        (legs[1]),
        .leg_c        (legs[0]),
        .state_vld    (vld),
        .cm_level     (lvl),
        .cm_step      (stp),
        .null_vec     (nul),
        .big_step_cnt (cnt)
    );

    function automatic int exp_level(logic [2:0] s);
        return 2 * (int'(s[0]) + int'(s[1]) + int'(s[2])) - 3;
    endfunction

    function automatic int exp_step(int a, int b);
        int d;
        d = a - b;
        if (d < 0) d = -d;
        return d / 2;
    endfunction

    function automatic string step_tag(int s);
        case (s)
            0:       return "R3";
            1:       return "R4";
            2:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, "/R2"}, "level", int'(lvl), m_level);
        chk(tag, "step", int'(stp), m_step);
        chk({tag, "/R7"}, "null", int'(nul), m_null);
        chk({tag, "/R9/R10"}, "count", int'(cnt), m_cnt);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        vld   = 1'b0;
        legs  = 3'b000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_level = -3;
        m_step  = 0;
        m_null  = 1;
        m_cnt   = 0;
    endtask

    task automatic step_in(logic [2:0] s, logic v);
        int ns;
        legs = s;
        vld  = v;
        @(posedge clk);
        @(negedge clk);
        vld = 1'b0;
        if (v) begin
            ns      = exp_level(s);
            m_step  = exp_step(ns, m_level);
            m_level = ns;
            m_null  = (s == 3'b000 || s == 3'b111) ? 1 : 0;
            if (m_step >= 2 && m_cnt < CMAX) m_cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        vld   = 1'b0;
        legs  = 3'b000;

        // R1: baseline after reset
        do_reset();
        check_all("R1");

        // R3 R4 R5 R6: every ordered pair of states
        for (int f = 0; f < 8; f++) begin
            for (int t = 0; t < 8; t++) begin
                do_reset();
                step_in(3'(f), 1'b1);
                step_in(3'(t), 1'b1);
                check_all(step_tag(exp_step(exp_level(3'(t)), exp_level(3'(f)))));
            end
        end

        // R9: worst-case steps past saturation; null flag and step 3 together
        do_reset();
        for (int i = 0; i < 20; i++) begin
            step_in((i % 2 == 0) ? 3'b111 : 3'b000, 1'b1);
            check_all("R6/R9");
        end
        chk("R9", "saturated count", int'(cnt), CMAX);

        // R10: small steps only, count stays at zero
        do_reset();
        for (int i = 0; i < 12; i++) begin
            step_in((i % 2 == 0) ? 3'b100 : 3'b101, 1'b1);
            check_all("R4/R10");
        end
        chk("R10", "count after small steps", int'(cnt), 0);

        // R8: legs ignored without strobe
        do_reset();
        step_in(3'b001, 1'b1);
        check_all("R8");
        step_in(3'b111, 1'b0);
        check_all("R8");
        step_in(3'b000, 1'b0);
        check_all("R8");
        step_in(3'b011, 1'b1);
        check_all("R8/R4");
        chk("R8", "step from last accepted", int'(stp), 1);

        // Random mix
        void'($urandom(32'd20240611));
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            step_in(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
            check_all(step_tag(m_step));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule